// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the sixteen logical general registers of a processor core together with the private register copies that certain processor modes own. The active mode is the low five bits of a current-status register kept inside the block. Two combinational read ports and one write port take a logical register number. A small index map turns that number into a slot of a 31-entry physical array. The slot depends on the active mode, so a mode change remaps the visible registers at once and no data moves.

Mode 0x11 (fast interrupt) owns private copies of R8 to R14. Modes 0x12, 0x13, 0x17 and 0x1B own private copies of R13 and R14 only. Each of these five exception modes also owns a saved-status register. The core writes that register through a dedicated port and reads it back. A restore command copies the saved status of the active mode into the current status, and the register mapping then follows the restored mode. If a restore is issued while no saved status exists, the status stays as it was and a one-cycle error flag goes high.

Top module: `mbrf_top`

## Requirements
- R1: After reset the current status reads 0x000000D3 (mode 0x13), the error flag is low, and every saved-status register reads zero.
- R2: The mode is bits 4:0 of the current status. Modes 0x10, 0x1F and any mode not listed in R3 or R4 see only the shared registers.
- R3: In mode 0x11, logical registers R8 to R14 map to a private set that no other mode can reach.
- R4: In modes 0x12, 0x13, 0x17 and 0x1B, R13 and R14 each map to a private pair owned by that mode, while R8 to R12 show the shared copies.
- R5: R0 to R7 and R15 are the same physical registers in every mode.
- R6: A status write takes effect on the next clock edge. A register write issued in the same cycle as a status write uses the mode that was active before the edge.
- R7: A saved-status write stores into the saved register of the active mode, and the saved-status output shows that register. In a mode without a saved register, the output reads zero and such writes are ignored.
- R8: A restore issued in one of the five exception modes loads the current status from that mode's saved register on the next edge, and the error flag stays low.
- R9: A restore issued in any other mode leaves the current status unchanged and drives the error flag high for exactly the one following cycle.
- R10: When a restore and a status write arrive in the same cycle, the restore takes precedence.
- R11: A read of the logical register being written in the same cycle returns the new write data.
- R12: The two read ports decode their register numbers independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_idx | input | 4 | Logical register number, read port A |
| rd_a_data | output | DW | Read data, port A |
| rd_b_idx | input | 4 | Logical register number, read port B |
| rd_b_data | output | DW | Read data, port B |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Logical register number for the write |
| wr_data | input | DW | Register write data |
| stat_wr_en | input | 1 | Current-status write enable |
| stat_wr_data | input | DW | New current-status value |
| stat_q | output | DW | Current status |
| saved_wr_en | input | 1 | Write enable for the active mode's saved status |
| saved_wr_data | input | DW | New saved-status value |
| saved_q | output | DW | Saved status of the active mode, zero if it has none |
| restore_cmd | input | 1 | Load current status from the active mode's saved status |
| restore_err | output | 1 | One-cycle flag marking a restore from a mode without saved status |

## Verification
The bench writes a distinct value into all sixteen registers in each of seven modes. It then steps through every ordered pair of modes and reads all sixteen registers on both ports. A wrong bank map shows up as a value from the wrong mode, for example R12 in mode 0x12 returning the fast-mode copy, or R13 in mode 0x1F returning a private copy. A register write issued in the same cycle as a mode change must land in the old mode's bank; a design that decoded with the new mode would corrupt the other bank. The restore checks cover a valid restore, a restore from modes 0x10 and 0x1F, which must pulse the error flag for one cycle without changing the status, and a restore that collides with a status write. The same-cycle read-after-write check catches a missing bypass, which would return the old value.

// File: rtl/mbrf_pkg.sv
package mbrf_pkg;

  localparam int NLOG     = 16;
  localparam int LIDX_W   = $clog2(NLOG);
  localparam int FAST_LO  = 8;
  localparam int FAST_N   = 7;
  localparam int EXC_LO   = 13;
  localparam int EXC_N    = 2;
  localparam int NEXC     = 4;
  localparam int FAST_BASE = NLOG;
  localparam int EXC_BASE  = FAST_BASE + FAST_N;
  localparam int NPHYS    = EXC_BASE + NEXC * EXC_N;
  localparam int PIDX_W   = $clog2(NPHYS);
  localparam int NSAVED   = NEXC + 1;

  localparam logic [4:0] MD_USER = 5'h10;
  localparam logic [4:0] MD_FAST = 5'h11;
  localparam logic [4:0] MD_IRQ  = 5'h12;
  localparam logic [4:0] MD_SUP  = 5'h13;
  localparam logic [4:0] MD_ABRT = 5'h17;
  localparam logic [4:0] MD_UNDF = 5'h1B;
  localparam logic [4:0] MD_SYS  = 5'h1F;

  typedef enum logic [2:0] {
    BK_SHARED = 3'd0,
    BK_FAST   = 3'd1,
    BK_IRQ    = 3'd2,
    BK_SUP    = 3'd3,
    BK_ABRT   = 3'd4,
    BK_UNDF   = 3'd5
  } bank_e;

  function automatic bank_e bank_of(input logic [4:0] mode);
    case (mode)
      MD_FAST: return BK_FAST;
      MD_IRQ:  return BK_IRQ;
      MD_SUP:  return BK_SUP;
      MD_ABRT: return BK_ABRT;
      MD_UNDF: return BK_UNDF;
      default: return BK_SHARED;
    endcase
  endfunction

endpackage

// File: rtl/mbrf_bank_map.sv
module mbrf_bank_map
  import mbrf_pkg::*;
(
  input  bank_e              bank,
  input  logic [LIDX_W-1:0]  lidx,
  output logic [PIDX_W-1:0]  pidx
);

  logic in_fast_rng;
  logic in_exc_rng;
  logic [2:0] exc_slot;

  always_comb begin
    in_fast_rng = (int'(lidx) >= FAST_LO) && (int'(lidx) < FAST_LO + FAST_N);
    in_exc_rng  = (int'(lidx) >= EXC_LO)  && (int'(lidx) < EXC_LO + EXC_N);
    exc_slot    = 3'(bank) - 3'(BK_IRQ);
    pidx        = PIDX_W'(lidx);
    if (bank == BK_FAST && in_fast_rng) begin
      pidx = PIDX_W'(FAST_BASE + int'(lidx) - FAST_LO);
    end else if (bank != BK_SHARED && bank != BK_FAST && in_exc_rng) begin
      pidx = PIDX_W'(EXC_BASE + int'(exc_slot) * EXC_N + int'(lidx) - EXC_LO);
    end
  end

endmodule

// File: rtl/mbrf_phys_array.sv
module mbrf_phys_array
  import mbrf_pkg::*;
#(
  parameter int DW    = 32,
  parameter int NRD   = 2
)(
  input  logic                     clk,
  input  logic                     we,
  input  logic [PIDX_W-1:0]        w_pidx,
  input  logic [DW-1:0]            w_data,
  input  logic [NRD-1:0][PIDX_W-1:0] r_pidx,
  output logic [NRD-1:0][DW-1:0]   r_data
);

  logic [DW-1:0] mem [NPHYS];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[w_pidx] <= w_data;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    always_comb begin
      if (we && (w_pidx == r_pidx[g])) begin
        r_data[g] = w_data;
      end else begin
        r_data[g] = mem[r_pidx[g]];
      end
    end
  end

endmodule

// File: rtl/mbrf_status.sv
module mbrf_status
  import mbrf_pkg::*;
#(
  parameter int          DW         = 32,
  parameter logic [DW-1:0] RST_STATUS = DW'(32'h0000_00D3)
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stat_wr_en,
  input  logic [DW-1:0] stat_wr_data,
  input  logic          saved_wr_en,
  input  logic [DW-1:0] saved_wr_data,
  input  logic          restore_cmd,
  output logic [DW-1:0] stat_q,
  output logic [DW-1:0] saved_q,
  output logic          restore_err,
  output bank_e         cur_bank
);

  logic [DW-1:0] stat_r, stat_nx;
  logic          err_r, err_nx;
  logic [DW-1:0] saved_r  [NSAVED];
  logic [DW-1:0] saved_nx [NSAVED];
  logic          saved_en [NSAVED];
  logic          has_saved;
  logic [2:0]    sv_slot;

  always_comb begin
    cur_bank  = bank_of(stat_r[4:0]);
    has_saved = (cur_bank != BK_SHARED);
    sv_slot   = 3'(cur_bank) - 3'd1;
    saved_q   = has_saved ? saved_r[sv_slot] : '0;
  end

  always_comb begin
    stat_nx = stat_r;
    err_nx  = 1'b0;
    if (restore_cmd) begin
      if (has_saved) begin
        stat_nx = saved_r[sv_slot];
      end else begin
        err_nx = 1'b1;
      end
    end else if (stat_wr_en) begin
      stat_nx = stat_wr_data;
    end
  end

  for (genvar g = 0; g < NSAVED; g++) begin : g_saved
    always_comb begin
      saved_en[g] = saved_wr_en && has_saved && (int'(sv_slot) == g);
      saved_nx[g] = saved_wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        saved_r[g] <= '0;
      end else if (saved_en[g]) begin
        saved_r[g] <= saved_nx[g];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_r <= RST_STATUS;
      err_r  <= 1'b0;
    end else begin
      stat_r <= stat_nx;
      err_r  <= err_nx;
    end
  end

  assign stat_q      = stat_r;
  assign restore_err = err_r;

endmodule

// File: rtl/mbrf_top.sv
module mbrf_top
  import mbrf_pkg::*;
#(
  parameter int DW = 32
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    rd_a_idx,
  output logic [DW-1:0] rd_a_data,
  input  logic [3:0]    rd_b_idx,
  output logic [DW-1:0] rd_b_data,
  input  logic          wr_en,
  input  logic [3:0]    wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          stat_wr_en,
  input  logic [DW-1:0] stat_wr_data,
  output logic [DW-1:0] stat_q,
  input  logic          saved_wr_en,
  input  logic [DW-1:0] saved_wr_data,
  output logic [DW-1:0] saved_q,
  input  logic          restore_cmd,
  output logic          restore_err
);

  localparam int NPORT = 3;
  localparam int NRD   = 2;

  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= '0;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync[1];

  bank_e cur_bank;

  mbrf_status #(.DW(DW)) u_status (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .stat_wr_en    (stat_wr_en),
    .stat_wr_data  (stat_wr_data),
    .saved_wr_en   (saved_wr_en),
    .saved_wr_data (saved_wr_data),
    .restore_cmd   (restore_cmd),
    .stat_q        (stat_q),
    .saved_q       (saved_q),
    .restore_err   (restore_err),
    .cur_bank      (cur_bank)
  );

  logic [NPORT-1:0][LIDX_W-1:0] l_idx;
  logic [NPORT-1:0][PIDX_W-1:0] p_idx;

  assign l_idx[0] = rd_a_idx;
  assign l_idx[1] = rd_b_idx;
  assign l_idx[2] = wr_idx;

  for (genvar g = 0; g < NPORT; g++) begin : g_map
    mbrf_bank_map u_map (
      .bank (cur_bank),
      .lidx (l_idx[g]),
      .pidx (p_idx[g])
    );
  end

  logic [NRD-1:0][PIDX_W-1:0] r_pidx;
  logic [NRD-1:0][DW-1:0]     r_data;

  assign r_pidx[0] = p_idx[0];
  assign r_pidx[1] = p_idx[1];

  mbrf_phys_array #(.DW(DW), .NRD(NRD)) u_array (
    .clk    (clk),
    .we     (wr_en),
    .w_pidx (p_idx[2]),
    .w_data (wr_data),
    .r_pidx (r_pidx),
    .r_data (r_data)
  );

  assign rd_a_data = r_data[0];
  assign rd_b_data = r_data[1];

endmodule

// File: rtl/mbrf_chk.sv
module mbrf_chk #(
  parameter int DW = 32
)(
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    rd_a_idx,
  input logic [DW-1:0] rd_a_data,
  input logic [3:0]    rd_b_idx,
  input logic [DW-1:0] rd_b_data,
  input logic          wr_en,
  input logic [3:0]    wr_idx,
  input logic [DW-1:0] wr_data,
  input logic          stat_wr_en,
  input logic [DW-1:0] stat_q,
  input logic [DW-1:0] saved_q,
  input logic          restore_cmd,
  input logic          restore_err
);

  logic has_saved;
  assign has_saved = (stat_q[4:0] == 5'h11) || (stat_q[4:0] == 5'h12) ||
                     (stat_q[4:0] == 5'h13) || (stat_q[4:0] == 5'h17) ||
                     (stat_q[4:0] == 5'h1B);

  AST_RESTORE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (restore_cmd && has_saved) |=> (stat_q == $past(saved_q)) && !restore_err) // R8
    else $error("restore did not load saved status");

  AST_RESTORE_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    (restore_cmd && !has_saved) |=> restore_err && $stable(stat_q)) // R9
    else $error("bad restore not flagged");

  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !restore_cmd |=> !restore_err) // R9
    else $error("error flag without restore");

  AST_STAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!restore_cmd && !stat_wr_en) |=> $stable(stat_q)) // R6
    else $error("status changed without a command");

  AST_NO_SAVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !has_saved |-> (saved_q == '0)) // R7
    else $error("saved status visible in unbanked mode");

  AST_BYPASS_A: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == rd_a_idx) |-> (rd_a_data == wr_data)) // R11
    else $error("port A bypass");

  AST_BYPASS_B: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == rd_b_idx) |-> (rd_b_data == wr_data)) // R11
    else $error("port B bypass");

endmodule

bind mbrf_top mbrf_chk #(.DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rd_a_idx    (rd_a_idx),
  .rd_a_data   (rd_a_data),
  .rd_b_idx    (rd_b_idx),
  .rd_b_data   (rd_b_data),
  .wr_en       (wr_en),
  .wr_idx      (wr_idx),
  .wr_data     (wr_data),
  .stat_wr_en  (stat_wr_en),
  .stat_q      (stat_q),
  .saved_q     (saved_q),
  .restore_cmd (restore_cmd),
  .restore_err (restore_err)
);

// File: tb/mbrf_top_test.sv
`timescale 1ns/1ps
module mbrf_top_test;

  localparam int DW = 32;

  logic          clk;
  logic          rst_n;
  logic [3:0]    rd_a_idx, rd_b_idx, wr_idx;
  logic [DW-1:0] rd_a_data, rd_b_data, wr_data;
  logic          wr_en, stat_wr_en, saved_wr_en, restore_cmd;
  logic [DW-1:0] stat_wr_data, stat_q, saved_wr_data, saved_q;
  logic          restore_err;

  mbrf_top #(.DW(DW)) uut (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .stat_wr_en(stat_wr_en), .stat_wr_data(stat_wr_data), .stat_q(stat_q),
    .saved_wr_en(saved_wr_en), .saved_wr_data(saved_wr_data), .saved_q(saved_q),
    .restore_cmd(restore_cmd), .restore_err(restore_err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  logic [DW-1:0] mdl [6][16];
  logic [4:0] modes [7] = '{5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F};

  function automatic int grp(input logic [4:0] m);
    case (m)
      5'h11: return 1;
      5'h12: return 2;
      5'h13: return 3;
      5'h17: return 4;
      5'h1B: return 5;
      default: return 0;
    endcase
  endfunction

  function automatic int owner(input logic [4:0] m, input int r);
    if (r >= 8 && r <= 12) return (m == 5'h11) ? 1 : 0;
    if (r == 13 || r == 14) return grp(m);
    return 0;
  endfunction

  function automatic logic [DW-1:0] stat_of(input logic [4:0] m);
    return {24'h0, 3'b110, m};
  endfunction

  task automatic chk(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic set_mode(input logic [4:0] m);
    @(negedge clk);
    stat_wr_en = 1'b1; stat_wr_data = stat_of(m);
    @(negedge clk);
    stat_wr_en = 1'b0;
  endtask

  task automatic wr_reg(input logic [4:0] m, input int r, input logic [DW-1:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'(r); wr_data = v;
    mdl[owner(m, r)][r] = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic check_all(input logic [4:0] m);
    for (int r = 0; r < 16; r++) begin
      @(negedge clk);
      rd_a_idx = 4'(r); rd_b_idx = 4'((r + 5) % 16);
      #1;
      // R2 R3 R4 R5 bank map, R12 independent ports
      chk(rd_a_data, mdl[owner(m, r)][r], $sformatf("R3/R4/R5 mode %h r%0d port A", m, r));
      chk(rd_b_data, mdl[owner(m, (r + 5) % 16)][(r + 5) % 16],
          $sformatf("R12 mode %h r%0d port B", m, (r + 5) % 16));
    end
  endtask

  task automatic pair_sweep();
    for (int a = 0; a < 7; a++) begin
      for (int b = 0; b < 7; b++) begin
        set_mode(modes[a]); check_all(modes[a]);
        set_mode(modes[b]); check_all(modes[b]);
      end
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    rd_a_idx = '0; rd_b_idx = '0; wr_idx = '0; wr_data = '0;
    wr_en = 1'b0; stat_wr_en = 1'b0; stat_wr_data = '0;
    saved_wr_en = 1'b0; saved_wr_data = '0; restore_cmd = 1'b0;
    for (int g = 0; g < 6; g++) for (int r = 0; r < 16; r++) mdl[g][r] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(stat_q, 32'h0000_00D3, "R1 status");
    chk({31'h0, restore_err}, 32'h0, "R1 error flag");
    chk(saved_q, 32'h0, "R1 saved status");

    // fill every mode, forward order
    for (int i = 0; i < 7; i++) begin
      set_mode(modes[i]);
      chk(stat_q, stat_of(modes[i]), "R6 status write");
      for (int r = 0; r < 16; r++)
        wr_reg(modes[i], r, {8'h11, 3'b0, modes[i], 8'h5A, 4'h0, 4'(r)});
    end
    pair_sweep();

    // second round, reverse order, banked range only
    for (int i = 6; i >= 0; i--) begin
      set_mode(modes[i]);
      for (int r = 8; r < 15; r++)
        wr_reg(modes[i], r, {8'h22, 3'b0, modes[i], 8'hA5, 4'h1, 4'(r)});
    end
    pair_sweep();

    // R6: register write in the status-change cycle uses the old mode
    set_mode(5'h12);
    @(negedge clk);
    stat_wr_en = 1'b1; stat_wr_data = stat_of(5'h13);
    wr_en = 1'b1; wr_idx = 4'd13; wr_data = 32'hDEAD_0613;
    mdl[2][13] = 32'hDEAD_0613;
    @(negedge clk);
    stat_wr_en = 1'b0; wr_en = 1'b0;
    check_all(5'h13);
    set_mode(5'h12);
    check_all(5'h12);

    // R11 same-cycle bypass
    set_mode(5'h11);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'd9; wr_data = 32'hB0B0_0009; rd_a_idx = 4'd9; rd_b_idx = 4'd9;
    #1;
    chk(rd_a_data, 32'hB0B0_0009, "R11 bypass port A");
    chk(rd_b_data, 32'hB0B0_0009, "R11 bypass port B");
    mdl[1][9] = 32'hB0B0_0009;
    @(negedge clk);
    wr_en = 1'b0;

    // R7 saved status per mode
    for (int i = 1; i < 6; i++) begin
      set_mode(modes[i]);
      @(negedge clk);
      saved_wr_en = 1'b1; saved_wr_data = stat_of(modes[(i % 5) + 1]) | 32'h0F00_0000;
      @(negedge clk);
      saved_wr_en = 1'b0;
      chk(saved_q, stat_of(modes[(i % 5) + 1]) | 32'h0F00_0000, "R7 saved write");
    end
    set_mode(5'h10);
    @(negedge clk);
    saved_wr_en = 1'b1; saved_wr_data = 32'hFFFF_FFFF;
    @(negedge clk);
    saved_wr_en = 1'b0;
    chk(saved_q, 32'h0, "R7 no saved in mode 10");
    for (int i = 1; i < 6; i++) begin
      set_mode(modes[i]);
      chk(saved_q, stat_of(modes[(i % 5) + 1]) | 32'h0F00_0000, "R7 saved kept");
    end

    // R8 valid restore: mode 12 holds status with mode 13
    set_mode(5'h12);
    @(negedge clk);
    restore_cmd = 1'b1;
    @(negedge clk);
    restore_cmd = 1'b0;
    chk(stat_q, stat_of(5'h13) | 32'h0F00_0000, "R8 restore status");
    chk({31'h0, restore_err}, 32'h0, "R8 no error");
    check_all(5'h13);

    // R9 restore from unbanked modes
    for (int k = 0; k < 2; k++) begin
      set_mode(k == 0 ? 5'h10 : 5'h1F);
      @(negedge clk);
      restore_cmd = 1'b1;
      @(negedge clk);
      restore_cmd = 1'b0;
      chk(stat_q, stat_of(k == 0 ? 5'h10 : 5'h1F), "R9 status unchanged");
      chk({31'h0, restore_err}, 32'h1, "R9 error raised");
      @(negedge clk);
      chk({31'h0, restore_err}, 32'h0, "R9 error one cycle");
    end

    // R10 restore wins over status write; mode 17 saved holds mode 1B
    set_mode(5'h17);
    @(negedge clk);
    restore_cmd = 1'b1; stat_wr_en = 1'b1; stat_wr_data = stat_of(5'h10);
    @(negedge clk);
    restore_cmd = 1'b0; stat_wr_en = 1'b0;
    chk(stat_q, stat_of(5'h1B) | 32'h0F00_0000, "R10 restore priority");
    check_all(5'h1B);

    finish_run();
  end

endmodule